// File: doc/BRIEF.md
# Glitch-Free Reference Clock Switch

This block chooses which of two unrelated clocks, an internal reference and an external reference, drives a single switched clock output. A handover never produces a shortened high or low phase. The outgoing source is gated off while it is low. The output then stays low until the incoming source can be passed from the start of a clean high phase.

The choice comes either from a select pin or from a stored flag. A mode bit decides which of the two is used. The two directions of a switch use different handshakes. A move to the external clock is detected on a falling edge of the internal clock. The request is then carried into the external domain, and that domain opens its gate on an external falling edge. A move back to the internal clock depends on the level of the external clock. It completes on any internal falling edge at which the external clock is low, so a stopped-low external clock does not block the return. If the external clock is stuck high, the return never happens.

Top module: `refclk_switch`

## Requirements
- R1: While `rst` is high, `clk_out` is low. After `rst` is released, the internal source is selected and `clk_out` stays low until the first falling edge of `clk_int`. The first rising edge of `clk_int` after that falling edge appears on `clk_out`.
- R2: With `use_stored` = 0, `sel_pin` = 1 selects the internal source and `sel_pin` = 0 selects the external source. `stored_ext` has no effect.
- R3: With `use_stored` = 1, `stored_ext` = 1 selects the external source and `stored_ext` = 0 selects the internal source. `sel_pin` has no effect.
- R4: A request for the external source is acted on at a falling edge of `clk_int`, where the internal gate closes. `clk_out` then stays low for at least half an internal period. The external gate opens only at a falling edge of `clk_ext`, after SYNC_STAGES such edges, so the first output rise after the handover is a rise of `clk_ext`.
- R5: A request for the internal source completes at the first falling edge of `clk_int` at which `clk_ext` is low. The rising edge of `clk_int` that follows appears on `clk_out`. This also holds when `clk_ext` has stopped low.
- R6: While `clk_ext` is stuck high, a request for the internal source never completes and `clk_out` keeps following the external source, which is high. Once `clk_ext` toggles again, the switch completes.
- R7: At most one source gate is open at any time. Every high phase of `clk_out` is a complete high phase of one source.
- R8: Every low phase of `clk_out`, including the gap during a handover, lasts at least as long as the shorter of the two source half-periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal reference clock; the control logic runs on its falling edge |
| clk_ext | input | 1 | External reference clock, unrelated to `clk_int` |
| rst | input | 1 | Active-high reset, synchronous to the falling edge of `clk_int` |
| sel_pin | input | 1 | Select pin: 1 = internal, 0 = external (used when `use_stored` = 0) |
| use_stored | input | 1 | 0 = `sel_pin` decides, 1 = `stored_ext` decides |
| stored_ext | input | 1 | Stored choice: 1 = external, 0 = internal (used when `use_stored` = 1) |
| clk_out | output | 1 | Switched clock |

## Verification
The handover timing is stated in source-clock edges, not in fixed cycles.

- **Internal-side decisions:** a select change is made one nanosecond after a rising edge of `clk_int`. It takes effect at the next falling edge of `clk_int`. The bench therefore samples the R1 and R5 results one nanosecond after the following rising edge of `clk_int`.
- **Move to external:** this takes up to SYNC_STAGES+1 external periods. For that direction and for random sequences, the bench waits a settling window longer than the worst case. It then checks that `clk_out` follows the expected source 0.5 ns after each of that source's edges.
- **Pulse-width monitor:** a continuous monitor timestamps every edge of `clk_out` and checks each high and low phase against the source half-periods.
- **Edge alignment:** external edges are placed on odd picoseconds and internal edges on even ones, so no sample lands on a simultaneous edge.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic {
        ST_INT = 1'b0,
        ST_EXT = 1'b1
    } refsw_state_e;

    typedef struct packed {
        logic int_en;     // internal gate open
        logic ext_grant;  // request to open the external gate
        logic ext_kill;   // forces the external gate shut
    } refsw_gate_ctrl_t;

    localparam refsw_gate_ctrl_t CTRL_RESET    = '{int_en: 1'b0, ext_grant: 1'b0, ext_kill: 1'b1};
    localparam refsw_gate_ctrl_t CTRL_TO_EXT   = '{int_en: 1'b0, ext_grant: 1'b1, ext_kill: 1'b0};
    localparam refsw_gate_ctrl_t CTRL_BACK_INT = '{int_en: 1'b1, ext_grant: 1'b0, ext_kill: 1'b1};

    function automatic logic want_external(input logic use_stored,
                                           input logic sel_pin,
                                           input logic stored_ext);
        return use_stored ? stored_ext : ~sel_pin;
    endfunction

endpackage

// File: rtl/refsw_int_ctrl.sv
module refsw_int_ctrl
    import refsw_pkg::*;
(
    input  logic             clk_int,
    input  logic             rst,
    input  logic             clk_ext,
    input  logic             want_ext,
    output refsw_gate_ctrl_t ctrl
);

    refsw_state_e     st_q;
    refsw_gate_ctrl_t ctrl_q;

    // All decisions are taken while clk_int is low, so the internal gate
    // never changes in the middle of an internal high phase.
    always_ff @(negedge clk_int) begin
        if (rst) begin
            st_q   <= ST_INT;
            ctrl_q <= CTRL_RESET;
        end else begin
            case (st_q)
                ST_INT: begin
                    if (want_ext) begin
                        st_q   <= ST_EXT;
                        ctrl_q <= CTRL_TO_EXT;
                    end else begin
                        ctrl_q.int_en <= 1'b1;
                    end
                end
                ST_EXT: begin
                    // Level check on the external clock: it is low, so its
                    // gate can be shut without cutting a high phase.
                    if (!want_ext && !clk_ext) begin
                        st_q   <= ST_INT;
                        ctrl_q <= CTRL_BACK_INT;
                    end
                end
                default: begin
                    st_q   <= ST_INT;
                    ctrl_q <= CTRL_RESET;
                end
            endcase
        end
    end

    assign ctrl = ctrl_q;

    p_reset_gates_r1: assert property (@(negedge clk_int)
        rst |=> (!ctrl_q.int_en && ctrl_q.ext_kill && !ctrl_q.ext_grant));

    p_enter_ext_r4: assert property (@(negedge clk_int) disable iff (rst)
        (st_q == ST_INT && want_ext) |=> (!ctrl_q.int_en && ctrl_q.ext_grant && !ctrl_q.ext_kill));

    p_leave_ext_low_r5: assert property (@(negedge clk_int) disable iff (rst)
        (st_q == ST_EXT && !want_ext && !clk_ext) |=> (ctrl_q.int_en && ctrl_q.ext_kill && !ctrl_q.ext_grant));

    p_stuck_high_holds_r6: assert property (@(negedge clk_int) disable iff (rst)
        (st_q == ST_EXT && clk_ext) |=> (st_q == ST_EXT && !ctrl_q.int_en));

endmodule

// File: rtl/refsw_ext_gate.sv
module refsw_ext_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ext,
    input  logic ext_grant,
    input  logic ext_kill,
    output logic ext_open
);

    localparam int LAST = SYNC_STAGES - 1;

    // ext_kill is raised only while clk_ext is low, so the asynchronous
    // clear never cuts an external high phase.
    generate
        if (SYNC_STAGES < 2) begin : g_single
            logic open_q;
            always_ff @(negedge clk_ext or posedge ext_kill) begin
                if (ext_kill) open_q <= 1'b0;
                else          open_q <= ext_grant;
            end
            assign ext_open = open_q;
        end else begin : g_chain
            logic [LAST:0] chain_q;
            always_ff @(negedge clk_ext or posedge ext_kill) begin
                if (ext_kill) chain_q <= '0;
                else          chain_q <= {chain_q[LAST-1:0], ext_grant};
            end
            assign ext_open = chain_q[LAST];
        end
    endgenerate

    p_open_needs_grant_r7: assert property (@(negedge clk_ext) disable iff (ext_kill)
        ext_open |-> ext_grant);

endmodule

// File: rtl/refsw_out_combine.sv
module refsw_out_combine (
    input  logic clk_int,
    input  logic clk_ext,
    input  logic int_en,
    input  logic ext_open,
    input  logic ext_kill,
    output logic ext_live,
    output logic clk_out
);

    always_comb begin
        ext_live = ext_open & ~ext_kill;
        clk_out  = (clk_int & int_en) | (clk_ext & ext_live);
    end

endmodule

// File: rtl/refclk_switch.sv
module refclk_switch
    import refsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_int,
    input  logic clk_ext,
    input  logic rst,
    input  logic sel_pin,
    input  logic use_stored,
    input  logic stored_ext,
    output logic clk_out
);

    refsw_gate_ctrl_t ctrl;
    logic             want_ext;
    logic             ext_open;
    logic             ext_live;

    assign want_ext = want_external(use_stored, sel_pin, stored_ext);

    refsw_int_ctrl u_int_ctrl (
        .clk_int  (clk_int),
        .rst      (rst),
        .clk_ext  (clk_ext),
        .want_ext (want_ext),
        .ctrl     (ctrl)
    );

    refsw_ext_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ext_gate (
        .clk_ext   (clk_ext),
        .ext_grant (ctrl.ext_grant),
        .ext_kill  (ctrl.ext_kill),
        .ext_open  (ext_open)
    );

    refsw_out_combine u_out (
        .clk_int  (clk_int),
        .clk_ext  (clk_ext),
        .int_en   (ctrl.int_en),
        .ext_open (ext_open),
        .ext_kill (ctrl.ext_kill),
        .ext_live (ext_live),
        .clk_out  (clk_out)
    );

    p_one_gate_int_r7: assert property (@(posedge clk_int) disable iff (rst)
        !(ctrl.int_en && ext_live));

    p_one_gate_ext_r7: assert property (@(posedge clk_ext) disable iff (rst)
        !(ctrl.int_en && ext_live));

    p_low_in_reset_r1: assert property (@(posedge clk_int)
        rst |=> !clk_out);

endmodule

// File: tb/refclk_switch_tb_top.sv
`timescale 1ns/1ps
module refclk_switch_tb_top;

    localparam real INT_HALF = 5.0;
    localparam real TOL      = 0.002;

    logic clk_int = 1'b0;
    logic clk_ext = 1'b0;
    logic rst = 1'b1;
    logic sel_pin = 1'b1;
    logic use_stored = 1'b0;
    logic stored_ext = 1'b0;
    logic clk_out;

    real  ext_half = 7.312;   // even picoseconds keep external edges on odd ps
    bit   ext_run  = 1'b1;
    bit   ext_hold = 1'b0;

    int   n_chk  = 0;
    int   n_fail = 0;

    bit   mon_en = 1'b0;
    bit   have_r = 1'b0;
    bit   have_f = 1'b0;
    real  t_r = 0.0;
    real  t_f = 0.0;

    refclk_switch #(.SYNC_STAGES(2)) dut_i (
        .clk_int    (clk_int),
        .clk_ext    (clk_ext),
        .rst        (rst),
        .sel_pin    (sel_pin),
        .use_stored (use_stored),
        .stored_ext (stored_ext),
        .clk_out    (clk_out)
    );

    initial forever #(INT_HALF) clk_int = ~clk_int;

    initial begin
        #0.001;
        forever begin
            #(ext_half);
            if (ext_run || clk_ext != ext_hold) clk_ext = ~clk_ext;
        end
    end

    function automatic bit exp_ext(input bit mode, input bit pin, input bit flag);
        return mode ? flag : !pin;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f at %0t",
                     req, what, act, exp, $realtime);
        end
    endtask

    task automatic mon_on();
        have_r = 1'b0;
        have_f = 1'b0;
        mon_en = 1'b1;
    endtask

    // R7 / R8 pulse-width monitor
    initial forever begin
        @(clk_out);
        if (clk_out) begin
            if (mon_en && have_f)
                chk(($realtime - t_f) >= INT_HALF - TOL, "R8", "low phase width",
                    $realtime - t_f, INT_HALF);
            t_r = $realtime;
            have_r = 1'b1;
        end else begin
            if (mon_en && have_r) begin
                real w;
                w = $realtime - t_r;
                chk((w > INT_HALF - TOL && w < INT_HALF + TOL) ||
                    (w > ext_half - TOL && w < ext_half + TOL),
                    "R7", "high phase width", w, INT_HALF);
            end
            t_f = $realtime;
            have_f = 1'b1;
        end
    end

    // clk_out must follow the chosen source edge by edge
    task automatic check_follow(input bit src_ext, input int n, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (src_ext) @(posedge clk_ext); else @(posedge clk_int);
            #0.5;
            if (clk_out !== 1'b1) bad++;
            if (src_ext) @(negedge clk_ext); else @(negedge clk_int);
            #0.5;
            if (clk_out !== 1'b0) bad++;
        end
        chk(bad == 0, req, src_ext ? "follow external" : "follow internal",
            real'(bad), 0.0);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk_int);
        #(10.0 * ext_half);
    endtask

    task automatic drive(input bit mode, input bit pin, input bit flag);
        @(posedge clk_int);
        #1;
        use_stored = mode;
        sel_pin    = pin;
        stored_ext = flag;
    endtask

    initial begin
        #(1_000_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        real t_sw;
        int  bad;
        real halves [3];
        halves[0] = 7.312;
        halves[1] = 11.702;
        halves[2] = 16.118;

        // R1: reset behaviour
        repeat (4) @(posedge clk_int);
        #1;
        chk(clk_out === 1'b0, "R1", "low in reset", real'(clk_out), 0.0);
        rst = 1'b0;
        #2;
        chk(clk_out === 1'b0, "R1", "low before first internal fall", real'(clk_out), 0.0);
        @(posedge clk_int);
        #1;
        chk(clk_out === 1'b1, "R1", "first internal rise passed", real'(clk_out), 1.0);
        mon_on();
        check_follow(1'b0, 4, "R1");

        // R2 / R4: pin switches to external
        drive(1'b0, 1'b0, 1'b1);
        @(negedge clk_int);
        t_sw = $realtime;
        @(posedge clk_int);
        #1;
        chk(clk_out === 1'b0, "R4", "held low after internal gate close", real'(clk_out), 0.0);
        @(posedge clk_out);
        chk(clk_ext === 1'b1, "R4", "first rise comes from external", real'(clk_ext), 1.0);
        chk(($realtime - t_sw) >= INT_HALF - TOL, "R4", "low gap vs half internal period",
            $realtime - t_sw, INT_HALF);
        settle();
        check_follow(1'b1, 4, "R2");

        // R2: pin back to internal (external running)
        drive(1'b0, 1'b1, 1'b1);
        settle();
        check_follow(1'b0, 4, "R2");

        // R3: stored flag rules, pin ignored
        drive(1'b1, 1'b1, 1'b1);
        settle();
        check_follow(1'b1, 4, "R3");
        drive(1'b1, 1'b0, 1'b1);
        settle();
        check_follow(1'b1, 4, "R3");
        drive(1'b1, 1'b1, 1'b1);
        settle();
        check_follow(1'b1, 4, "R3");
        drive(1'b1, 1'b1, 1'b0);
        settle();
        check_follow(1'b0, 4, "R3");
        drive(1'b1, 1'b0, 1'b0);
        settle();
        check_follow(1'b0, 4, "R3");

        // R5: return to internal with external stopped low
        drive(1'b0, 1'b0, 1'b0);
        settle();
        check_follow(1'b1, 2, "R5");
        mon_en = 1'b0;
        ext_hold = 1'b0;
        ext_run  = 1'b0;
        #(4.0 * ext_half);
        drive(1'b0, 1'b1, 1'b0);
        @(posedge clk_int);
        #1;
        chk(clk_out === 1'b1, "R5", "next internal rise after stop-low switch",
            real'(clk_out), 1.0);
        check_follow(1'b0, 4, "R5");
        ext_run = 1'b1;

        // R6: external stuck high blocks the return
        drive(1'b0, 1'b0, 1'b0);
        settle();
        check_follow(1'b1, 2, "R6");
        ext_hold = 1'b1;
        ext_run  = 1'b0;
        #(4.0 * ext_half);
        drive(1'b0, 1'b1, 1'b0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_int);
            #1;
            if (clk_out !== 1'b1) bad++;
        end
        chk(bad == 0, "R6", "output parked on stuck-high external", real'(bad), 0.0);
        ext_run = 1'b1;
        settle();
        check_follow(1'b0, 4, "R6");
        mon_on();

        // Random mix of modes, pins, flags and external rates
        void'($urandom(32'h1f2e_3d4c));
        for (int it = 0; it < 40; it++) begin
            bit m, p, f;
            if (($urandom % 5) == 0) begin
                mon_en = 1'b0;
                ext_half = halves[$urandom % 3];
                #(4.0 * ext_half);
                mon_on();
            end
            m = 1'($urandom);
            p = 1'($urandom);
            f = 1'($urandom);
            drive(m, p, f);
            repeat ($urandom % 3) @(posedge clk_int);
            settle();
            check_follow(exp_ext(m, p, f), 3, exp_ext(m, p, f) ? "R2/R3 ext" : "R2/R3 int");
        end

        mon_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule